// File: doc/BRIEF.md
# Multiframe Begin and Data-Link Marker Generator

This block produces the frame-timing marks for a T1 stream, once for the receive side and once for the transmit side. Each side has its own frame-start strobe, superframe-start strobe and bit index. The block keeps a frame counter that runs modulo 24 and is forced back to zero by the superframe-start strobe. From that counter it decodes two one-cycle marks that line up with the F-bit of the frame concerned.

The first mark is the multiframe-begin pulse. One shared configuration bit decides whether this pulse appears only at the start of the 24-frame superframe, or also at its midpoint (every 12 frames). The second mark is the data-link marker. It is enabled by a second shared configuration bit, and it flags the F-bit of every other frame. At 8000 frames per second this gives a 4 kHz marker of the data-link bit position.

The block has no data path. All pins are plain control and status pins, so there is no valid/ready handshake and no back-pressure. Alignment search and data handling are done elsewhere.

Top module: `mfdl_marker`

## Requirements
- R1: After reset all four marker outputs are low, and the first frame strobe that follows is counted as frame number 0 (even without a superframe strobe), so it raises that side's multiframe-begin pulse.
- R2: A frame strobe given together with the superframe strobe forces the frame number to 0 at any point of the count and raises the multiframe-begin pulse.
- R3: With `cfg_sf_only` = 0, the multiframe-begin pulse is raised at frame numbers 0 and 12.
- R4: With `cfg_sf_only` = 1, the multiframe-begin pulse is raised only at frame number 0. Frame 12 gives no pulse.
- R5: Without superframe strobes, each frame strobe advances the frame number by one, and the number wraps from 23 back to 0.
- R6: With `cfg_dl_mark` = 1, the data-link marker is raised on frames with an even frame number (0, 2, … 22; these are the 1st, 3rd, … 23rd frames). That is 12 per superframe.
- R7: With `cfg_dl_mark` = 0, both data-link marker outputs stay low.
- R8: A mark is high only during the single cycle in which the frame strobe is high and the bit index equals 0 (the F-bit). If the frame strobe comes with any other bit index, the frame number still advances but no mark is produced.
- R9: The receive and transmit sides count and mark independently. Strobes on one side never move the other side's count or outputs.
- R10: A superframe strobe without a frame strobe in the same cycle has no effect on the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_sf_only | input | 1 | 1: multiframe-begin pulse at the superframe start only; 0: also at frame 12 |
| cfg_dl_mark | input | 1 | 1: enable the data-link markers |
| rx_frame_stb | input | 1 | Receive frame-start strobe |
| rx_sf_stb | input | 1 | Receive superframe-start strobe |
| rx_bit_idx | input | BIT_W | Receive bit index within the frame |
| tx_frame_stb | input | 1 | Transmit frame-start strobe |
| tx_sf_stb | input | 1 | Transmit superframe-start strobe |
| tx_bit_idx | input | BIT_W | Transmit bit index within the frame |
| rx_mf_begin | output | 1 | Receive multiframe-begin pulse |
| rx_dl_mark | output | 1 | Receive data-link bit marker |
| tx_mf_begin | output | 1 | Transmit multiframe-begin pulse |
| tx_dl_mark | output | 1 | Transmit data-link bit marker |

## Verification
The bench builds the block with its default parameters: 24 frames per superframe, an 8-bit bit index and the F-bit at index 0. The bench shortens each frame to a few bit-clock cycles instead of 193. This keeps full superframes and repeated 23-to-0 wraps within a short run, so every frame number is visited on both sides and in both pulse modes. The F-bit position is fixed at 0, so a strobe given with a nonzero index exercises the misaligned case directly.

// File: rtl/mfdl_pkg.sv
package mfdl_pkg;

  // Marks produced for one direction in one cycle.
  typedef struct packed {
    logic mf_begin;
    logic dl_mark;
  } mark_t;

  localparam int N_DIRS = 2;  // index 0 = receive, 1 = transmit

endpackage

// File: rtl/mfdl_frame_ctr.sv
// Frame counter for one direction. cur_num is the number of the frame
// that starts in the current cycle (valid while frame_stb is high).
module mfdl_frame_ctr #(
  parameter int FRAMES = 24,
  localparam int CW = $clog2(FRAMES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frame_stb,
  input  logic          sf_stb,
  output logic [CW-1:0] cur_num
);

  localparam logic [CW-1:0] LAST = CW'(FRAMES - 1);

  logic [CW-1:0] cnt_q;

  always_comb begin
    if (sf_stb)
      cur_num = '0;
    else if (cnt_q == LAST)
      cur_num = '0;
    else
      cur_num = cnt_q + 1'b1;
  end

  // Reset to the last number so the first frame after reset is frame 0.
  always_ff @(posedge clk) begin
    if (!rst_n)
      cnt_q <= LAST;
    else if (frame_stb)
      cnt_q <= cur_num;
  end

endmodule

// File: rtl/mfdl_mark_dec.sv
// Decodes the multiframe-begin and data-link marks for one direction.
module mfdl_mark_dec
  import mfdl_pkg::*;
#(
  parameter int FRAMES = 24,
  parameter int BIT_W  = 8,
  parameter int F_POS  = 0,
  localparam int CW    = $clog2(FRAMES),
  localparam int HALF  = FRAMES / 2
) (
  input  logic [CW-1:0]    cur_num,
  input  logic             frame_stb,
  input  logic [BIT_W-1:0] bit_idx,
  input  logic             sf_only,
  input  logic             dl_en,
  output mark_t            marks
);

  logic at_fbit;
  logic is_start;
  logic is_half;

  assign at_fbit  = frame_stb && (bit_idx == BIT_W'(F_POS));
  assign is_start = (cur_num == '0);
  assign is_half  = (cur_num == CW'(HALF));

  always_comb begin
    marks.mf_begin = at_fbit && (is_start || (!sf_only && is_half));
    marks.dl_mark  = at_fbit && dl_en && !cur_num[0];
  end

endmodule

// File: rtl/mfdl_marker.sv
module mfdl_marker
  import mfdl_pkg::*;
#(
  parameter int FRAMES_PER_SF = 24,
  parameter int BIT_W         = 8,
  parameter int F_POS         = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_sf_only,
  input  logic             cfg_dl_mark,
  input  logic             rx_frame_stb,
  input  logic             rx_sf_stb,
  input  logic [BIT_W-1:0] rx_bit_idx,
  input  logic             tx_frame_stb,
  input  logic             tx_sf_stb,
  input  logic [BIT_W-1:0] tx_bit_idx,
  output logic             rx_mf_begin,
  output logic             rx_dl_mark,
  output logic             tx_mf_begin,
  output logic             tx_dl_mark
);

  localparam int CW = $clog2(FRAMES_PER_SF);

  logic [N_DIRS-1:0]            fstb;
  logic [N_DIRS-1:0]            sstb;
  logic [N_DIRS-1:0][BIT_W-1:0] bidx;
  mark_t                        mk [N_DIRS];

  assign fstb = {tx_frame_stb, rx_frame_stb};
  assign sstb = {tx_sf_stb, rx_sf_stb};
  assign bidx = {tx_bit_idx, rx_bit_idx};

  for (genvar d = 0; d < N_DIRS; d++) begin : g_dir
    logic [CW-1:0] num;

    mfdl_frame_ctr #(
      .FRAMES (FRAMES_PER_SF)
    ) ctr_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .frame_stb (fstb[d]),
      .sf_stb    (sstb[d]),
      .cur_num   (num)
    );

    mfdl_mark_dec #(
      .FRAMES (FRAMES_PER_SF),
      .BIT_W  (BIT_W),
      .F_POS  (F_POS)
    ) dec_i (
      .cur_num   (num),
      .frame_stb (fstb[d]),
      .bit_idx   (bidx[d]),
      .sf_only   (cfg_sf_only),
      .dl_en     (cfg_dl_mark),
      .marks     (mk[d])
    );
  end

  assign rx_mf_begin = mk[0].mf_begin;
  assign rx_dl_mark  = mk[0].dl_mark;
  assign tx_mf_begin = mk[1].mf_begin;
  assign tx_dl_mark  = mk[1].dl_mark;

endmodule

// File: rtl/mfdl_marker_chk.sv
module mfdl_marker_chk #(
  parameter int BIT_W = 8,
  parameter int F_POS = 0
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_dl_mark,
  input logic             rx_frame_stb,
  input logic             rx_sf_stb,
  input logic [BIT_W-1:0] rx_bit_idx,
  input logic             tx_frame_stb,
  input logic             tx_sf_stb,
  input logic [BIT_W-1:0] tx_bit_idx,
  input logic             rx_mf_begin,
  input logic             rx_dl_mark,
  input logic             tx_mf_begin,
  input logic             tx_dl_mark
);

  // R8
  rx_mf_fbit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_mf_begin |-> (rx_frame_stb && rx_bit_idx == BIT_W'(F_POS)));
  // R8
  tx_mf_fbit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_mf_begin |-> (tx_frame_stb && tx_bit_idx == BIT_W'(F_POS)));
  // R8
  rx_dl_fbit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_dl_mark |-> (rx_frame_stb && rx_bit_idx == BIT_W'(F_POS)));
  // R8
  tx_dl_fbit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_dl_mark |-> (tx_frame_stb && tx_bit_idx == BIT_W'(F_POS)));
  // R7
  dl_off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_dl_mark |-> (!rx_dl_mark && !tx_dl_mark));
  // R2
  rx_sf_forces_mf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_frame_stb && rx_sf_stb && rx_bit_idx == BIT_W'(F_POS)) |-> rx_mf_begin);
  // R2
  tx_sf_forces_mf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_frame_stb && tx_sf_stb && tx_bit_idx == BIT_W'(F_POS)) |-> tx_mf_begin);
  // R6
  rx_start_is_dl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_dl_mark && rx_mf_begin && rx_sf_stb) |-> rx_dl_mark);
  // R6
  tx_start_is_dl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_dl_mark && tx_mf_begin && tx_sf_stb) |-> tx_dl_mark);

endmodule

bind mfdl_marker mfdl_marker_chk #(
  .BIT_W (BIT_W),
  .F_POS (F_POS)
) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .cfg_dl_mark  (cfg_dl_mark),
  .rx_frame_stb (rx_frame_stb),
  .rx_sf_stb    (rx_sf_stb),
  .rx_bit_idx   (rx_bit_idx),
  .tx_frame_stb (tx_frame_stb),
  .tx_sf_stb    (tx_sf_stb),
  .tx_bit_idx   (tx_bit_idx),
  .rx_mf_begin  (rx_mf_begin),
  .rx_dl_mark   (rx_dl_mark),
  .tx_mf_begin  (tx_mf_begin),
  .tx_dl_mark   (tx_dl_mark)
);

// File: tb/mfdl_marker_tb_top.sv
module mfdl_marker_tb_top;

  localparam int FR = 24;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_sf_only = 1'b0;
  logic       cfg_dl_mark = 1'b0;
  logic       rx_frame_stb = 1'b0;
  logic       rx_sf_stb = 1'b0;
  logic [7:0] rx_bit_idx = 8'd1;
  logic       tx_frame_stb = 1'b0;
  logic       tx_sf_stb = 1'b0;
  logic [7:0] tx_bit_idx = 8'd1;
  logic       rx_mf_begin, rx_dl_mark, tx_mf_begin, tx_dl_mark;

  int n_chk = 0;
  int n_bad = 0;
  int rx_n = FR - 1;   // model: number of the last counted frame
  int tx_n = FR - 1;
  bit done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  mfdl_marker dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_sf_only  (cfg_sf_only),
    .cfg_dl_mark  (cfg_dl_mark),
    .rx_frame_stb (rx_frame_stb),
    .rx_sf_stb    (rx_sf_stb),
    .rx_bit_idx   (rx_bit_idx),
    .tx_frame_stb (tx_frame_stb),
    .tx_sf_stb    (tx_sf_stb),
    .tx_bit_idx   (tx_bit_idx),
    .rx_mf_begin  (rx_mf_begin),
    .rx_dl_mark   (rx_dl_mark),
    .tx_mf_begin  (tx_mf_begin),
    .tx_dl_mark   (tx_dl_mark)
  );

  task automatic check(input string tag, input string what, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %b expected %b", tag, what, act, exp);
    end
  endtask

  task automatic check_quiet(input string tag);
    check(tag, "rx_mf_begin", rx_mf_begin, 1'b0);
    check(tag, "rx_dl_mark",  rx_dl_mark,  1'b0);
    check(tag, "tx_mf_begin", tx_mf_begin, 1'b0);
    check(tag, "tx_dl_mark",  tx_dl_mark,  1'b0);
  endtask

  // One frame strobe on one side; expected marks come from the model count.
  task automatic send_frame(input bit is_tx, input bit sf, input logic [7:0] idx, input string tag);
    int  n;
    bit  al;
    logic emf, edl;
    n   = sf ? 0 : (((is_tx ? tx_n : rx_n) + 1) % FR);
    al  = (idx == 8'd0);
    emf = al && (n == 0 || (!cfg_sf_only && n == FR / 2));
    edl = al && cfg_dl_mark && (n % 2 == 0);
    @(negedge clk);
    if (is_tx) begin
      tx_frame_stb = 1'b1; tx_sf_stb = sf; tx_bit_idx = idx;
    end else begin
      rx_frame_stb = 1'b1; rx_sf_stb = sf; rx_bit_idx = idx;
    end
    #5;
    if (is_tx) begin
      check(tag, $sformatf("tx_mf_begin frame %0d", n), tx_mf_begin, emf);
      check(tag, $sformatf("tx_dl_mark frame %0d", n),  tx_dl_mark,  edl);
      check("R9", "rx_mf_begin idle", rx_mf_begin, 1'b0);
    end else begin
      check(tag, $sformatf("rx_mf_begin frame %0d", n), rx_mf_begin, emf);
      check(tag, $sformatf("rx_dl_mark frame %0d", n),  rx_dl_mark,  edl);
      check("R9", "tx_mf_begin idle", tx_mf_begin, 1'b0);
    end
    @(posedge clk);
    if (is_tx) tx_n = n; else rx_n = n;
    @(negedge clk);
    rx_frame_stb = 1'b0; rx_sf_stb = 1'b0; rx_bit_idx = 8'd1;
    tx_frame_stb = 1'b0; tx_sf_stb = 1'b0; tx_bit_idx = 8'd1;
    #5;
    check_quiet("R8");  // one-cycle pulse
  endtask

  task automatic t_reset();
    @(negedge clk); #5;
    check_quiet("R1");
    send_frame(1'b0, 1'b0, 8'd0, "R1");
    send_frame(1'b1, 1'b0, 8'd0, "R1");
  endtask

  task automatic t_every12();
    cfg_sf_only = 1'b0; cfg_dl_mark = 1'b0;
    send_frame(1'b0, 1'b1, 8'd0, "R3");
    for (int i = 1; i < FR; i++) send_frame(1'b0, 1'b0, 8'd0, "R3");
    send_frame(1'b1, 1'b1, 8'd0, "R3");
    for (int i = 1; i < FR; i++) send_frame(1'b1, 1'b0, 8'd0, "R3");
  endtask

  task automatic t_sf_only();
    cfg_sf_only = 1'b1;
    send_frame(1'b0, 1'b1, 8'd0, "R4");
    for (int i = 1; i < FR; i++) send_frame(1'b0, 1'b0, 8'd0, "R4");
    cfg_sf_only = 1'b0;
  endtask

  task automatic t_wrap();
    for (int i = 0; i < 2 * FR + 3; i++) send_frame(1'b1, 1'b0, 8'd0, "R5");
  endtask

  task automatic t_dl();
    cfg_dl_mark = 1'b1;
    send_frame(1'b0, 1'b1, 8'd0, "R6");
    for (int i = 1; i < FR; i++) send_frame(1'b0, 1'b0, 8'd0, "R6");
    send_frame(1'b1, 1'b1, 8'd0, "R6");
    for (int i = 1; i < 5; i++) send_frame(1'b1, 1'b0, 8'd0, "R6");
  endtask

  task automatic t_dl_off();
    cfg_dl_mark = 1'b0;
    for (int i = 0; i < 6; i++) send_frame(1'b0, 1'b0, 8'd0, "R7");
  endtask

  task automatic t_misaligned();
    cfg_dl_mark = 1'b1;
    send_frame(1'b0, 1'b1, 8'd5, "R8");    // counted as 0, no mark
    send_frame(1'b0, 1'b0, 8'd0, "R8");    // frame 1
    send_frame(1'b0, 1'b0, 8'd17, "R8");   // frame 2, no mark
    send_frame(1'b0, 1'b0, 8'd0, "R8");    // frame 3
  endtask

  task automatic t_resync();
    send_frame(1'b1, 1'b0, 8'd0, "R2");
    send_frame(1'b1, 1'b0, 8'd0, "R2");
    send_frame(1'b1, 1'b1, 8'd0, "R2");    // forced back to 0
    send_frame(1'b1, 1'b0, 8'd0, "R2");
  endtask

  task automatic t_sf_alone();
    @(negedge clk);
    rx_sf_stb = 1'b1; tx_sf_stb = 1'b1;
    #5;
    check_quiet("R10");
    @(negedge clk);
    rx_sf_stb = 1'b0; tx_sf_stb = 1'b0;
    send_frame(1'b0, 1'b0, 8'd0, "R10");
    send_frame(1'b1, 1'b0, 8'd0, "R10");
  endtask

  task automatic t_independent();
    for (int i = 0; i < 7; i++) send_frame(1'b1, 1'b0, 8'd0, "R9");
    send_frame(1'b0, 1'b0, 8'd0, "R9");
    send_frame(1'b1, 1'b1, 8'd0, "R9");
    send_frame(1'b0, 1'b0, 8'd0, "R9");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    t_reset();
    t_every12();
    t_sf_only();
    t_wrap();
    t_dl();
    t_dl_off();
    t_misaligned();
    t_resync();
    t_sf_alone();
    t_independent();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule